// File: doc/BRIEF.md
# Loadable Pulse Divider with Chain Feedback

This block divides an external pulse stream by a value N that it loads from a 4-bit preset bus. It holds a count register that steps down by one on every qualifying pin event. It also raises a flag when the count reaches zero. Two external pins qualify events: a count pin and a hold pin. A rising count pin is an event while the hold pin is low. A falling hold pin is an event while the count pin is high, so the hold pin can also act as a negative-edge clock. Both pins are resampled into the system clock domain before edges are found, so all state lives in that one domain.

For single-stage division, wire the zero flag back to the load-enable input. The counter then reloads N each time it reaches zero, and the flag pulses once for every N input events. For wider divisors, several stages are chained. The chain-feedback input gates the zero decode, and one stage's zero flag can clock the next stage. The top stage's flag then drives the load enable of every stage, and no glue logic is needed.

Top module: `divn_down_counter`

## Requirements
- R1: `clear` is asynchronous and active high. It forces the count to 0 and overrides `load_en` and all events.
- R2: A rising `cnt_pin` while `hold_pin` is low lowers the count by exactly one.
- R3: While `hold_pin` stays high, a rising `cnt_pin` leaves the count unchanged.
- R4: A falling `hold_pin` while `cnt_pin` is high lowers the count by exactly one.
- R5: If a rising `cnt_pin` and a falling `hold_pin` reach the edge logic in the same system cycle, the count drops by one, not two.
- R6: While `load_en` is high, each system clock edge copies `load_val` into the count. The load wins over any pin event, so the value holds for as long as the enable stays high.
- R7: An event at count 0 with `load_en` low wraps the count to all ones (15 for the default width).
- R8: `zero_flag` is high exactly when the count is 0 and `chain_fb` is high. It is a combinational decode of the count register.
- R9: A pin level sampled at system edge k changes the count at edge k+2. Counted from a change driven between edges, the count moves on the third rising system edge.
- R10: With `zero_flag` looped to `load_en` and `chain_fb` high, the flag is high for one system cycle per N input pulses, for every N from 1 to 15.
- R11: Two stages are chained as follows. The low stage has `chain_fb` high and counts the input. The high stage's `cnt_pin` and `chain_fb` both take the low stage's `zero_flag`. The high stage's flag drives both `load_en` inputs. With presets H (high stage) and L (low stage, 1 to 15), the chain's flag pulses once per L+16·(H−1) input pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock that samples the pins and clocks all state |
| clear | input | 1 | Asynchronous active-high reset; count goes to 0 |
| cnt_pin | input | 1 | External count pin; its rising edge is an event when hold is low |
| hold_pin | input | 1 | External hold pin; high blocks count-pin edges, and its falling edge is an event when cnt_pin is high |
| load_en | input | 1 | Level load enable; high copies load_val into the count |
| load_val | input | W (4) | Preset value N |
| chain_fb | input | 1 | Chain feedback; gates the zero decode |
| count | output | W (4) | Current count |
| zero_flag | output | 1 | High when the count is 0 and chain_fb is high |

## Verification
The bench goes after four cases.

- **Coincident edges.** The two pin edges reach the edge logic in the same cycle. A design that adds the events would fall by two.
- **Wrap below zero.** A design that saturates at zero would stick there instead of showing 15.
- **Load over events.** A pin event arrives while the load enable is high. A design that lets events win would drift below the preset.
- **Synchronizer delay.** The count must move on the third system edge. An off-by-one stage count shows up as an early or late step.

The bench also closes the zero-to-load loop for every N from 1 to 15, and chains two stages to divide by 100. A decode that ignored the feedback, or reloaded one event late, would give N+1 or a wrong chain ratio. A per-cycle reference model compares the count and the flag on every clock.

// File: rtl/divn_pkg.sv
package divn_pkg;
  typedef enum logic [1:0] {ACT_IDLE, ACT_LOAD, ACT_STEP} act_e;

  // Next value when stepping down: wraps from zero to all ones.
  function automatic int unsigned step_down(int unsigned v, int unsigned w);
    int unsigned top;
    top = (32'd1 << w) - 32'd1;
    return (v == 0) ? top : v - 32'd1;
  endfunction

  // Terminal decode: zero count qualified by chain feedback.
  function automatic logic is_terminal(int unsigned v, logic fb);
    return (v == 0) && fb;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic clear,
  input  logic pin,
  output logic lvl
);
  logic [STAGES-1:0] sh;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or posedge clear)
          if (clear) sh[0] <= RST_VAL;
          else       sh[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or posedge clear)
          if (clear) sh[i] <= RST_VAL;
          else       sh[i] <= sh[i-1];
      end
    end
  endgenerate

  assign lvl = sh[STAGES-1];
endmodule

// File: rtl/edge_qual.sv
module edge_qual (
  input  logic clk,
  input  logic clear,
  input  logic clk_lvl,
  input  logic inh_lvl,
  output logic rise_seen,
  output logic fall_seen,
  output logic cnt_evt
);
  logic clk_prev, inh_prev;

  // Reset values chosen so that no edge is seen just after clear.
  always_ff @(posedge clk or posedge clear)
    if (clear) begin
      clk_prev <= 1'b1;
      inh_prev <= 1'b0;
    end else begin
      clk_prev <= clk_lvl;
      inh_prev <= inh_lvl;
    end

  assign rise_seen = clk_lvl & ~clk_prev & ~inh_lvl;
  assign fall_seen = inh_prev & ~inh_lvl & clk_lvl;
  // Coincident qualifying edges merge into one event.
  assign cnt_evt   = rise_seen | fall_seen;

  // R3: a hold level that stays high produces no event.
  a_r3_hold_blocks: assert property (@(posedge clk) disable iff (clear)
    (inh_lvl && inh_prev) |-> !cnt_evt);
  // R4: a falling hold while the count pin is high is an event.
  a_r4_hold_fall_counts: assert property (@(posedge clk) disable iff (clear)
    (inh_prev && !inh_lvl && clk_lvl) |-> cnt_evt);
endmodule

// File: rtl/down_stage.sv
module down_stage
  import divn_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         clear,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] count
);
  act_e act;

  always_comb begin
    if (load_en)   act = ACT_LOAD;
    else if (step) act = ACT_STEP;
    else           act = ACT_IDLE;
  end

  always_ff @(posedge clk or posedge clear)
    if (clear) count <= '0;
    else begin
      case (act)
        ACT_LOAD: count <= load_val;
        ACT_STEP: count <= W'(step_down(32'(count), W));
        default:  count <= count;
      endcase
    end

  // R6: load wins and copies the preset.
  a_r6_load_wins: assert property (@(posedge clk) disable iff (clear)
    load_en |=> count == $past(load_val));
  // R2: one event lowers a non-zero count by one.
  a_r2_single_step: assert property (@(posedge clk) disable iff (clear)
    (!load_en && step && count != '0) |=> count == W'($past(count) - 1'b1));
  // R7: stepping from zero wraps to all ones.
  a_r7_wrap: assert property (@(posedge clk) disable iff (clear)
    (!load_en && step && count == '0) |=> count == '1);
  // R3: no event and no load leaves the count alone.
  a_r3_idle_holds: assert property (@(posedge clk) disable iff (clear)
    (!load_en && !step) |=> $stable(count));
endmodule

// File: rtl/divn_down_counter.sv
module divn_down_counter
  import divn_pkg::*;
#(
  parameter int W           = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         sys_clk,
  input  logic         clear,
  input  logic         cnt_pin,
  input  logic         hold_pin,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         chain_fb,
  output logic [W-1:0] count,
  output logic         zero_flag
);
  logic clk_lvl, inh_lvl;
  logic rise_seen, fall_seen, cnt_evt;

  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cnt (
    .clk(sys_clk), .clear(clear), .pin(cnt_pin), .lvl(clk_lvl));

  pin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hold (
    .clk(sys_clk), .clear(clear), .pin(hold_pin), .lvl(inh_lvl));

  edge_qual u_edge (
    .clk(sys_clk), .clear(clear), .clk_lvl(clk_lvl), .inh_lvl(inh_lvl),
    .rise_seen(rise_seen), .fall_seen(fall_seen), .cnt_evt(cnt_evt));

  down_stage #(.W(W)) u_stage (
    .clk(sys_clk), .clear(clear), .load_en(load_en), .load_val(load_val),
    .step(cnt_evt), .count(count));

  assign zero_flag = is_terminal(32'(count), chain_fb);

  // R1: clear holds the count at zero regardless of load.
  always @(posedge sys_clk)
    if (clear) a_r1_clear_zero: assert (count == '0);
  // R5: coincident edges still step by exactly one.
  a_r5_one_step: assert property (@(posedge sys_clk) disable iff (clear)
    (rise_seen && fall_seen && !load_en && count != '0)
      |=> count == W'($past(count) - 1'b1));
  // R8: with feedback low the flag never rises.
  a_r8_fb_gates: assert property (@(posedge sys_clk) disable iff (clear)
    !chain_fb |-> !zero_flag);
endmodule

// File: tb/divn_down_counter_tb.sv
`timescale 1ns/1ps
module divn_down_counter_tb;
  logic clk = 1'b0;
  logic clear = 1'b1;
  logic cnt_pin = 1'b0, hold_pin = 1'b0, pe_drive = 1'b0, fb = 1'b0, lb = 1'b0;
  logic [3:0] pval = 4'd0;
  logic [3:0] cnt;
  logic zero;
  wire pe = lb ? zero : pe_drive;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divn_down_counter u_dut (
    .sys_clk(clk), .clear(clear), .cnt_pin(cnt_pin), .hold_pin(hold_pin),
    .load_en(pe), .load_val(pval), .chain_fb(fb), .count(cnt), .zero_flag(zero));

  // Cascade pair for R11: H=7, L=4 gives 4 + 16*6 = 100.
  logic c_in = 1'b0;
  logic [3:0] c_lo, c_hi;
  logic z_lo, z_hi;
  divn_down_counter u_lo (
    .sys_clk(clk), .clear(clear), .cnt_pin(c_in), .hold_pin(1'b0),
    .load_en(z_hi), .load_val(4'd4), .chain_fb(1'b1), .count(c_lo), .zero_flag(z_lo));
  divn_down_counter u_hi (
    .sys_clk(clk), .clear(clear), .cnt_pin(z_lo), .hold_pin(1'b0),
    .load_en(z_hi), .load_val(4'd7), .chain_fb(z_lo), .count(c_hi), .zero_flag(z_hi));

  // Behavioural reference model: pin history lists and an integer count.
  int m_cnt;
  int ch[4];
  int ih[4];
  always @(posedge clk or posedge clear) begin
    if (clear) begin
      m_cnt = 0;
      foreach (ch[i]) begin ch[i] = 1; ih[i] = 0; end
    end else begin
      bit evt, ld, mz;
      evt = (ch[2] == 1 && ch[3] == 0 && ih[2] == 0) ||
            (ih[3] == 1 && ih[2] == 0 && ch[2] == 1);
      mz  = (m_cnt == 0) && fb;
      ld  = lb ? mz : pe_drive;
      if (ld)       m_cnt = pval;
      else if (evt) m_cnt = (m_cnt + 15) % 16;
      for (int i = 3; i > 1; i--) begin ch[i] = ch[i-1]; ih[i] = ih[i-1]; end
      ch[1] = cnt_pin; ih[1] = hold_pin;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 per-cycle comparison with the model, away from the edge.
  int zc = 0, zc_c = 0;
  always @(posedge clk) begin
    #2;
    if (!clear && !done) begin
      check(cnt == 4'(m_cnt), "R9 model count", cnt, m_cnt);
      check(zero == ((m_cnt == 0) && fb), "R8 model zero", zero, (m_cnt == 0) && fb);
      if (zero && lb) zc++;
      if (z_hi) zc_c++;
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    cnt_pin = 1'b1; cyc(5); cnt_pin = 1'b0; cyc(5);
  endtask

  task automatic load(logic [3:0] v);
    pval = v; pe_drive = 1'b1; cyc(1); pe_drive = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #750000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(3);
    clear = 1'b0;
    cyc(2);
    check(cnt == 4'd0, "R1 reset count", cnt, 0);

    load(4'd9); cyc(1);
    check(cnt == 4'd9, "R6 load", cnt, 9);

    pulse(); cyc(2);
    check(cnt == 4'd8, "R2 rising step", cnt, 8);

    hold_pin = 1'b1; cyc(4); pulse(); pulse(); cyc(2);
    check(cnt == 4'd8, "R3 hold blocks", cnt, 8);

    cnt_pin = 1'b1; cyc(4); hold_pin = 1'b0; cyc(5); cnt_pin = 1'b0; cyc(4);
    check(cnt == 4'd7, "R4 hold fall step", cnt, 7);

    hold_pin = 1'b1; cyc(5);
    cnt_pin = 1'b1; hold_pin = 1'b0; cyc(5); cnt_pin = 1'b0; cyc(4);
    check(cnt == 4'd6, "R5 coincident single step", cnt, 6);

    pval = 4'd5; pe_drive = 1'b1; pulse(); pulse();
    check(cnt == 4'd5, "R6 load holds over events", cnt, 5);
    pe_drive = 1'b0; cyc(2);

    // R9 latency: drive, then two edges unchanged, third edge steps.
    cnt_pin = 1'b1;
    @(posedge clk); @(posedge clk); #1;
    check(cnt == 4'd5, "R9 not before third edge", cnt, 5);
    @(posedge clk); #1;
    check(cnt == 4'd4, "R9 on third edge", cnt, 4);
    cyc(4); cnt_pin = 1'b0; cyc(5);

    load(4'd0); cyc(1);
    fb = 1'b0; cyc(1);
    check(zero == 1'b0, "R8 fb low masks zero", zero, 0);
    fb = 1'b1; cyc(1);
    check(zero == 1'b1, "R8 zero flag", zero, 1);
    fb = 1'b0;
    pulse(); cyc(2);
    check(cnt == 4'd15, "R7 wrap", cnt, 15);

    load(4'd11); cyc(1);
    pe_drive = 1'b1; clear = 1'b1; cyc(2);
    check(cnt == 4'd0, "R1 clear beats load", cnt, 0);
    pe_drive = 1'b0; clear = 1'b0; cyc(3);

    fb = 1'b1;
    for (int n = 1; n <= 15; n++) begin
      load(4'(n)); cyc(1);
      zc = 0; lb = 1'b1;
      repeat (3 * n) pulse();
      cyc(10);
      check(zc == 3, $sformatf("R10 divide by %0d", n), zc, 3);
      lb = 1'b0; cyc(2);
    end

    // R11: restart chain from reset, then 300 pulses give 3 flags.
    fb = 1'b0;
    clear = 1'b1; cyc(2); clear = 1'b0; cyc(5);
    zc_c = 0;
    check(c_hi == 4'd7 && c_lo == 4'd4, "R11 chain preset", {c_hi, c_lo}, 8'h74);
    repeat (300) begin
      c_in = 1'b1; cyc(5); c_in = 1'b0; cyc(5);
    end
    cyc(10);
    check(zc_c == 3, "R11 chain divide by 100", zc_c, 3);
    check(c_hi == 4'd7 && c_lo == 4'd4, "R11 chain reloaded", {c_hi, c_lo}, 8'h74);

    finish_run();
  end
endmodule